// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel, double-buffered digital-to-analog converter. A host writes it over a 3-wire serial link (serial data, serial clock, active-low chip select). Each frame carries a 2-bit channel selector and then a `CODE_W`-bit code. When chip select rises, the selector routes the code into the input register of channel A, channel B, both, or neither. An active-low, level-sensitive load input copies both input registers into the DAC registers. Holding the load input low makes every write show up at the outputs directly.

All link pins are oversampled in the system clock domain. Each passes through a `SYNC_STAGES`-deep synchronizer, and edge detectors then find serial clock rises and chip-select rises. An active-low reset loads every register with a preset. A mode pin picks the preset: zero scale, or midscale (only the top code bit set). The reset is sampled on the system clock. Power-on is handled by holding it low at start-up. The two outputs are the DAC register codes that drive the analog ladders.

Top module: `dacif_top`

## Requirements
- R1: A frame is sent most significant bit first. The first bit is selector bit 1, then selector bit 0, then the code from bit `CODE_W-1` down to bit 0. Each bit is sampled on a rising edge of the serial clock.
- R2: The shift register advances only while chip select is low. Serial clock edges while chip select is high leave it unchanged. A chip-select pulse with no clock edges re-decodes the frame already held.
- R3: When a burst is longer than `CODE_W+2` bits, only the last `CODE_W+2` bits are decoded and the earlier bits are discarded.
- R4: On the rising edge of chip select, the selector is decoded as follows: 01 writes channel A, 10 writes channel B, 11 writes the same code to both, and 00 writes nothing.
- R5: While the load input is high, both DAC registers hold their value, even when input registers are written. A later low level on the load input moves both channels to the outputs together.
- R6: While the load input is low, each DAC register follows its input register. In that state, a write reaches the output in the same cycle that the input register takes it.
- R7: While reset is low, both input registers and both DAC registers hold the preset. The preset is all zeros when the mode pin is 0, and `1 << (CODE_W-1)` (0x8000 for 16 bits) when it is 1. The shift register clears to an all-zero frame, which is a no-op.
- R8: Reset takes priority over a chip-select transfer and over the load input. Serial activity during reset leaves every register at the preset after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Active-low synchronous reset that loads the preset |
| mode_mid | input | 1 | Preset select: 0 gives zero scale, 1 gives midscale |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_cs_n | input | 1 | Active-low chip select; its rising edge decodes the frame |
| load_n | input | 1 | Active-low, level-sensitive load from the input registers to the DAC registers |
| dac_a | output | CODE_W | DAC register code of channel A |
| dac_b | output | CODE_W | DAC register code of channel B |

## Verification
The bench sends directed frames with each selector value. These show whether the decode reaches the right channel, and whether selector 00 truly leaves both channels alone. Bursts with junk leading bits check that only the tail of a burst is decoded. Serial clocks sent while chip select is high, followed by an empty chip-select pulse, show whether the shift register moved when it should have held. Random frames of random length, written with the load input either held low or pulsed after the write, are checked against a bench model. These separate the transparent path from the double-buffered one. Resets with both mode values, with frames and load activity during reset, tell the two presets apart and show that reset wins.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  // Channel selector carried at the head of every serial frame
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_BOTH = 2'b11
  } dacif_sel_e;

  localparam int unsigned NUM_CH = 2;

  // Write mask, bit 0 = channel A, bit 1 = channel B
  function automatic logic [NUM_CH-1:0] sel_to_mask(input logic [1:0] sel);
    logic [NUM_CH-1:0] mask;
    case (dacif_sel_e'(sel))
      SEL_A:    mask = 2'b01;
      SEL_B:    mask = 2'b10;
      SEL_BOTH: mask = 2'b11;
      default:  mask = 2'b00;
    endcase
    return mask;
  endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
  parameter int unsigned FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);

  // Holds only the newest FRAME_W bits; older bits fall off the top
  always_ff @(posedge clk) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
  end

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] preset,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              load_en,
  output logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] dac_q
);

  logic [CODE_W-1:0] in_next;

  always_comb in_next = wr_en ? wr_code : in_q;

  // The DAC register takes the next input value so transparent mode adds no lag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= preset;
      dac_q <= preset;
    end else begin
      in_q <= in_next;
      if (load_en) dac_q <= in_next;
    end
  end

endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int unsigned CODE_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_mid,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_cs_n,
  input  logic              load_n,
  output logic [CODE_W-1:0] dac_a,
  output logic [CODE_W-1:0] dac_b
);

  localparam int unsigned FRAME_W = CODE_W + 2;
  localparam int unsigned PIN_W   = 4;
  // idle levels: serial clock low, data low, chip select high, load high
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0011;

  function automatic logic [CODE_W-1:0] preset_code(input logic mid);
    logic [CODE_W-1:0] v;
    v = '0;
    v[CODE_W-1] = mid;
    return v;
  endfunction

  logic [PIN_W-1:0]   pins_s;
  logic               s_sclk, s_sdi, s_cs_n, s_load_n;
  logic               sclk_q, cs_q;
  logic               shift_stb, xfer_stb, load_en;
  logic [FRAME_W-1:0] frame;
  logic [1:0]         frame_sel;
  logic [CODE_W-1:0]  frame_code;
  logic [NUM_CH-1:0]  wr_mask;
  logic [CODE_W-1:0]  preset;
  logic [CODE_W-1:0]  in_code  [NUM_CH];
  logic [CODE_W-1:0]  dac_code [NUM_CH];
  logic [CODE_W-1:0]  in_a, in_b;

  dacif_sync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_clk, ser_data, ser_cs_n, load_n}),
    .q     (pins_s)
  );

  assign {s_sclk, s_sdi, s_cs_n, s_load_n} = pins_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= s_sclk;
      cs_q   <= s_cs_n;
    end
  end

  // Named internal events
  assign shift_stb = s_sclk & ~sclk_q & ~s_cs_n;
  assign xfer_stb  = s_cs_n & ~cs_q;
  assign load_en   = ~s_load_n;

  dacif_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_stb),
    .bit_in   (s_sdi),
    .frame    (frame)
  );

  assign frame_sel  = frame[FRAME_W-1 -: 2];
  assign frame_code = frame[CODE_W-1:0];
  assign wr_mask    = xfer_stb ? sel_to_mask(frame_sel) : '0;
  assign preset     = preset_code(mode_mid);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dacif_chan #(.CODE_W(CODE_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (preset),
        .wr_en   (wr_mask[c]),
        .wr_code (frame_code),
        .load_en (load_en),
        .in_q    (in_code[c]),
        .dac_q   (dac_code[c])
      );
    end
  endgenerate

  assign in_a  = in_code[0];
  assign in_b  = in_code[1];
  assign dac_a = dac_code[0];
  assign dac_b = dac_code[1];

endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
  parameter int unsigned CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_mid,
  input logic              xfer_stb,
  input logic              load_en,
  input logic [1:0]        frame_sel,
  input logic [CODE_W-1:0] frame_code,
  input logic [CODE_W-1:0] in_a,
  input logic [CODE_W-1:0] in_b,
  input logic [CODE_W-1:0] dac_a,
  input logic [CODE_W-1:0] dac_b
);

  logic              rst_seen_q;
  logic [CODE_W-1:0] exp_preset_q;

  always_ff @(posedge clk) begin
    if (rst_seen_q === 1'b1) begin
      AST_PRESET_DAC: assert (dac_a == exp_preset_q && dac_b == exp_preset_q); // R7
      AST_RESET_WINS: assert (in_a == exp_preset_q && in_b == exp_preset_q);   // R8
    end
    rst_seen_q   <= !rst_n;
    exp_preset_q <= mode_mid ? (CODE_W'(1) << (CODE_W-1)) : '0;
  end

  AST_SEL_NONE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && frame_sel == 2'b00) |=> ($stable(in_a) && $stable(in_b))); // R4

  AST_SEL_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && frame_sel[0]) |=> (in_a == $past(frame_code))); // R4

  AST_SEL_B_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && frame_sel[1]) |=> (in_b == $past(frame_code))); // R4

  AST_HOLD_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(dac_a) && $stable(dac_b))); // R5

  AST_FOLLOW_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (dac_a == in_a && dac_b == in_b)); // R6

endmodule

bind dacif_top dacif_checker #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_mid   (mode_mid),
  .xfer_stb   (xfer_stb),
  .load_en    (load_en),
  .frame_sel  (frame_sel),
  .frame_code (frame_code),
  .in_a       (in_a),
  .in_b       (in_b),
  .dac_a      (dac_a),
  .dac_b      (dac_b)
);

// File: tb/tb_dacif_top.sv
module tb_dacif_top;

  localparam int unsigned CW = 16;
  localparam int unsigned FW = CW + 2;
  localparam int unsigned HB = 4; // system clocks per serial half bit

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_mid = 1'b0;
  logic          ser_clk = 1'b0;
  logic          ser_data = 1'b0;
  logic          ser_cs_n = 1'b1;
  logic          load_n = 1'b1;
  logic [CW-1:0] dac_a, dac_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [CW-1:0] m_in_a, m_in_b, m_dac_a, m_dac_b;

  always #10 clk = ~clk; // 50 MHz

  dacif_top #(.CODE_W(CW), .SYNC_STAGES(2)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_mid (mode_mid),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_cs_n (ser_cs_n),
    .load_n   (load_n),
    .dac_a    (dac_a),
    .dac_b    (dac_b)
  );

  function automatic logic [CW-1:0] bench_preset(input logic mid);
    return mid ? CW'(32'h1 << (CW - 1)) : '0;
  endfunction

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    check(req, dac_a, m_dac_a);
    check(req, dac_b, m_dac_b);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Model of a decoded write: selector bit 0 -> A, bit 1 -> B
  task automatic model_write(input logic [1:0] sel, input logic [CW-1:0] code);
    if (sel[0]) m_in_a = code;
    if (sel[1]) m_in_b = code;
    if (!load_n) begin
      m_dac_a = m_in_a;
      m_dac_b = m_in_b;
    end
  endtask

  task automatic serial_bit(input logic b);
    ser_data = b;
    wait_clk(HB);
    ser_clk = 1'b1;
    wait_clk(HB);
    ser_clk = 1'b0;
  endtask

  // Sends the low len bits of word, highest first, inside one chip-select window
  task automatic send_burst(input logic [63:0] word, input int len);
    ser_cs_n = 1'b0;
    wait_clk(HB);
    for (int i = len - 1; i >= 0; i--) serial_bit(word[i]);
    wait_clk(HB);
    ser_cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic write_frame(input logic [1:0] sel, input logic [CW-1:0] code,
                             input int extra, input logic [63:0] junk);
    logic [63:0] w;
    w = (junk << FW) | {46'd0, sel, code};
    send_burst(w, FW + extra);
    model_write(sel, code);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(6);
    load_n = 1'b1;
    wait_clk(6);
    m_dac_a = m_in_a;
    m_dac_b = m_in_b;
  endtask

  task automatic apply_reset(input logic mid);
    mode_mid = mid;
    rst_n = 1'b0;
    wait_clk(4);
    m_in_a = bench_preset(mid); m_in_b = m_in_a;
    m_dac_a = m_in_a; m_dac_b = m_in_a;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [1:0]    sel;
    logic [CW-1:0] code;
    int            extra;
    void'($urandom(32'd2024));

    // R7: power-on reset with zero-scale preset
    apply_reset(1'b0);
    check_out("R7 reset zero scale");
    rst_n = 1'b1;
    wait_clk(4);

    // Transparent mode: load held low
    load_n = 1'b0;
    wait_clk(6);
    write_frame(2'b01, 16'h1234, 0, 64'd0);
    check_out("R1 R4 R6 write A");
    write_frame(2'b10, 16'hBEEF, 0, 64'd0);
    check_out("R4 write B");
    write_frame(2'b11, 16'h0F0F, 0, 64'd0);
    check_out("R4 broadcast");
    write_frame(2'b00, 16'hFFFF, 0, 64'd0);
    check_out("R4 selector 00 no-op");

    // R3: 24-bit burst with six junk leading ones
    write_frame(2'b01, 16'hA5A5, 6, 64'h3F);
    check_out("R3 over-length burst");

    // R2: clocks while chip select is high must not shift
    for (int i = 0; i < FW; i++) serial_bit(1'b1);
    wait_clk(6);
    send_burst(64'd0, 0);
    model_write(2'b01, 16'hA5A5);
    check_out("R2 no shift while deselected");

    // R5: double buffering with load high
    load_n = 1'b1;
    wait_clk(6);
    write_frame(2'b01, 16'h1111, 0, 64'd0);
    check_out("R5 hold A while load high");
    write_frame(2'b10, 16'h2222, 0, 64'd0);
    check_out("R5 hold B while load high");
    pulse_load();
    check_out("R5 simultaneous update");

    // Random frames, both load styles
    for (int it = 0; it < 30; it++) begin
      sel   = 2'($urandom());
      code  = CW'($urandom());
      extra = int'($urandom() % 9);
      if ($urandom() % 2 == 0) begin
        load_n = 1'b0;
        wait_clk(6);
        write_frame(sel, code, extra, 64'($urandom()));
        check_out("R6 R4 R3 random transparent");
      end else begin
        load_n = 1'b1;
        wait_clk(6);
        write_frame(sel, code, extra, 64'($urandom()));
        check_out("R5 R4 random buffered pre-load");
        pulse_load();
        check_out("R5 R1 random buffered post-load");
      end
    end

    // R8: reset to midscale with frame and load activity during reset
    load_n = 1'b1;
    wait_clk(6);
    apply_reset(1'b1);
    check_out("R7 reset midscale");
    load_n = 1'b0;
    send_burst({46'd0, 2'b11, 16'h7777}, FW);
    check_out("R8 reset beats transfer");
    rst_n = 1'b1;
    wait_clk(6);
    check_out("R8 preset after release");
    load_n = 1'b1;
    wait_clk(6);
    pulse_load();
    check_out("R8 input regs still preset");
    check("R7 midscale value", dac_a, 16'h8000);

    // R7: back to zero scale after writes
    load_n = 1'b0;
    wait_clk(6);
    write_frame(2'b11, 16'h4321, 0, 64'd0);
    check_out("R4 broadcast before reset");
    apply_reset(1'b0);
    check_out("R7 reset zero after writes");
    rst_n = 1'b1;
    wait_clk(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule